// File: doc/BRIEF.md
# Serial Servo Command Receiver

This block takes commands from a control microcontroller over a three-wire serial link. The link has a framing strobe, a data line and a shift clock. While the strobe is high, the block shifts in data bits on each rising edge of the shift clock. When the strobe falls, it judges what it has collected. A window holding exactly eight bits is a one-byte command. A window holding sixteen bits is a two-byte command. A window of any other length is dropped.

Accepted commands drive the following outputs:

- level outputs for mute, disc motor run, jump direction and VCO multiply select;
- single-cycle pulses for focus start and track jump;
- an 8-bit track-count register;
- a small general-purpose output port.

The three link inputs are asynchronous to the system clock, so they pass through a two-stage synchroniser before edge detection. A command takes effect four system clocks after the strobe low level reaches the block's input pins.

Two commands carry a data byte. The track-count command takes two strobe windows. The first window (code 0xB0) is held pending until a second eight-bit window arrives, and that second byte is loaded as the count. The port-write command sends both bytes in one sixteen-bit window.

Top module: `servo_cmd_rx`

## Requirements
- R1: After synchronous reset the outputs are as follows: mute, motor_run, jump_reverse and vco_x2 are 0; track_count and port_out are 0; focus_pulse and jump_pulse are low.
- R2: Bits are taken MSB first, on rising edges of cmd_clk, and only while cmd_strobe is high. Clock edges while the strobe is low are ignored. For example, sending 0x02 does not act as 0x40.
- R3: A command takes effect only after cmd_strobe falls. Outputs do not change while the strobe is still high after the last bit. The new values are visible within 8 system clocks after the fall.
- R4: Code 0x30 sets mute to 1, and code 0x31 sets it to 0. The level is held until the next mute command.
- R5: Code 0x40 sets motor_run to 1 (start), and code 0x41 sets it to 0 (stop). The level is held.
- R6: Code 0x08 produces exactly one focus_pulse, one system clock wide.
- R7: Code 0x20 produces one jump_pulse, one clock wide, and sets jump_reverse to 0. Code 0x21 does the same but sets jump_reverse to 1. focus_pulse and jump_pulse are never high together.
- R8: Code 0xAC sets vco_x2 to 1 (times-two). Code 0xAD sets it to 0 (times-one, the reset setting).
- R9: An eight-bit window of 0xB0 makes the track-count command pending. The byte of the next eight-bit window is loaded into track_count, whatever its value, and is not executed as a command.
- R10: A pending track-count command is cancelled by an intervening sixteen-bit window. After the cancellation, the next eight-bit window executes as an ordinary command and track_count is unchanged.
- R11: A sixteen-bit window whose first byte is 0xC0 loads the low 5 bits of its second byte into port_out.
- R12: A window whose bit count is neither 8 nor 16 changes no output and leaves a pending track-count command pending.
- R13: A cmd_clk rising edge that happens together with the fall of cmd_strobe counts as the window's last bit.
- R14: Eight-bit codes not listed here (for example 0x77) change no output. A sixteen-bit window whose first byte is not 0xC0 also changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_strobe | input | 1 | Command framing strobe, high during a window |
| cmd_clk | input | 1 | Serial shift clock, data taken on rising edge |
| cmd_data | input | 1 | Serial command data, MSB first |
| mute | output | 1 | Audio mute level |
| motor_run | output | 1 | Disc motor run level |
| focus_pulse | output | 1 | One-cycle focus start request |
| jump_pulse | output | 1 | One-cycle track jump request |
| jump_reverse | output | 1 | Direction of the last jump request |
| vco_x2 | output | 1 | VCO multiply select, 1 = times two |
| track_count | output | 8 | Track count loaded by the two-window command |
| port_out | output | 5 | General-purpose output port value |

## Verification
The delicate coincidence is a shift-clock rising edge that reaches the block in the same system cycle as the strobe fall. Both the bit append and the window evaluation act on that cycle. The bench provokes it by raising cmd_clk and lowering cmd_strobe in the same instant, on the last bit of a mute-on command. Both inputs pass through identical synchroniser depths, so the two edges are detected together. The result is judged at the ports: mute must rise, which shows the eighth bit was counted and the window was not dropped as a seven-bit window.

// File: rtl/srx_pkg.sv
// Package srx_pkg
// Shared sizes and command codes for the serial servo command receiver.
// Assumes eight-bit command bytes; a word is two bytes.
package srx_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] OP_FOCUS    = 8'h08;
    localparam logic [BYTE_W-1:0] OP_JUMP_FWD = 8'h20;
    localparam logic [BYTE_W-1:0] OP_JUMP_REV = 8'h21;
    localparam logic [BYTE_W-1:0] OP_MUTE_ON  = 8'h30;
    localparam logic [BYTE_W-1:0] OP_MUTE_OFF = 8'h31;
    localparam logic [BYTE_W-1:0] OP_MOT_RUN  = 8'h40;
    localparam logic [BYTE_W-1:0] OP_MOT_STOP = 8'h41;
    localparam logic [BYTE_W-1:0] OP_VCO_X2   = 8'hAC;
    localparam logic [BYTE_W-1:0] OP_VCO_X1   = 8'hAD;
    localparam logic [BYTE_W-1:0] OP_TRK_CNT  = 8'hB0;
    localparam logic [BYTE_W-1:0] OP_PORT_WR  = 8'hC0;

    typedef enum logic [1:0] {
        WIN_BAD  = 2'd0,
        WIN_ONE  = 2'd1,
        WIN_TWO  = 2'd2
    } win_kind_e;
endpackage

// File: rtl/srx_sync.sv
// Module srx_sync
// Multi-bit, multi-stage flip-flop synchroniser for asynchronous inputs.
// Assumes each bit is independent (no bus coherency needed).
module srx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // Purpose: one register stage of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[gi] <= '0;
                else if (gi == 0) stg[gi] <= d;
                else stg[gi] <= stg[(gi == 0) ? 0 : gi-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/srx_shifter.sv
// Module srx_shifter
// Collects serial bits inside a strobe window and reports the window
// contents with a one-cycle valid when the strobe falls.
// Assumes synchronised inputs; a clock edge seen in the same cycle as the
// strobe fall belongs to the closing window.
module srx_shifter
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              sck,
    input  logic              sd,
    output logic              win_v,
    output win_kind_e         win_kind,
    output logic [WORD_W-1:0] win_word
);
    localparam int CNT_MAX = WORD_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic              stb_d, sck_d;
    logic [WORD_W-1:0] sh, nxt_sh;
    logic [CNT_W-1:0]  cnt, nxt_cnt;
    logic              sck_rise, win_end, take;
    win_kind_e         kind_c;

    assign sck_rise = sck & ~sck_d;
    assign win_end  = stb_d & ~stb;
    assign take     = sck_rise & (stb | stb_d);

    // Purpose: next shift register and saturating bit count.
    always_comb begin
        nxt_sh  = sh;
        nxt_cnt = cnt;
        if (take) begin
            nxt_sh = {sh[WORD_W-2:0], sd};
            if (cnt != CNT_W'(CNT_MAX)) nxt_cnt = cnt + 1'b1;
        end
    end

    // Purpose: classify the closing window by its bit count.
    always_comb begin
        if (nxt_cnt == CNT_W'(BYTE_W))      kind_c = WIN_ONE;
        else if (nxt_cnt == CNT_W'(WORD_W)) kind_c = WIN_TWO;
        else                                kind_c = WIN_BAD;
    end

    // Purpose: edge history, bit collection and window report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_d    <= 1'b0;
            sck_d    <= 1'b0;
            sh       <= '0;
            cnt      <= '0;
            win_v    <= 1'b0;
            win_kind <= WIN_BAD;
            win_word <= '0;
        end else begin
            stb_d <= stb;
            sck_d <= sck;
            win_v <= 1'b0;
            if (win_end) begin
                win_v    <= 1'b1;
                win_kind <= kind_c;
                win_word <= nxt_sh;
                sh       <= '0;
                cnt      <= '0;
            end else if (stb) begin
                sh  <= nxt_sh;
                cnt <= nxt_cnt;
            end else begin
                sh  <= '0;
                cnt <= '0;
            end
        end
    end

    assert_win_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        win_v |=> !win_v);

    assert_idle_no_report_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb && !stb_d) |=> !win_v);
endmodule

// File: rtl/srx_exec.sv
// Module srx_exec
// Decodes reported windows and drives the control outputs; keeps the
// pending state of the two-window track-count command.
// Assumes win_v is a one-cycle pulse per closed window.
module srx_exec
    import srx_pkg::*;
#(
    parameter int PORT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_v,
    input  win_kind_e         win_kind,
    input  logic [WORD_W-1:0] win_word,
    output logic              mute,
    output logic              motor_run,
    output logic              focus_pulse,
    output logic              jump_pulse,
    output logic              jump_reverse,
    output logic              vco_x2,
    output logic [BYTE_W-1:0] track_count,
    output logic [PORT_W-1:0] port_out
);
    logic              pending;
    logic [BYTE_W-1:0] lo_byte, hi_byte;
    logic              one_v, two_v;

    assign lo_byte = win_word[BYTE_W-1:0];
    assign hi_byte = win_word[WORD_W-1:BYTE_W];
    assign one_v   = win_v && (win_kind == WIN_ONE);
    assign two_v   = win_v && (win_kind == WIN_TWO);

    // Purpose: execute commands and hold the level outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mute         <= 1'b0;
            motor_run    <= 1'b0;
            focus_pulse  <= 1'b0;
            jump_pulse   <= 1'b0;
            jump_reverse <= 1'b0;
            vco_x2       <= 1'b0;
            track_count  <= '0;
            port_out     <= '0;
            pending      <= 1'b0;
        end else begin
            focus_pulse <= 1'b0;
            jump_pulse  <= 1'b0;
            if (one_v) begin
                if (pending) begin
                    track_count <= lo_byte;
                    pending     <= 1'b0;
                end else begin
                    case (lo_byte)
                        OP_FOCUS:    focus_pulse <= 1'b1;
                        OP_JUMP_FWD: begin jump_pulse <= 1'b1; jump_reverse <= 1'b0; end
                        OP_JUMP_REV: begin jump_pulse <= 1'b1; jump_reverse <= 1'b1; end
                        OP_MUTE_ON:  mute <= 1'b1;
                        OP_MUTE_OFF: mute <= 1'b0;
                        OP_MOT_RUN:  motor_run <= 1'b1;
                        OP_MOT_STOP: motor_run <= 1'b0;
                        OP_VCO_X2:   vco_x2 <= 1'b1;
                        OP_VCO_X1:   vco_x2 <= 1'b0;
                        OP_TRK_CNT:  pending <= 1'b1;
                        default:     ;
                    endcase
                end
            end else if (two_v) begin
                pending <= 1'b0;
                if (hi_byte == OP_PORT_WR) port_out <= lo_byte[PORT_W-1:0];
            end
        end
    end

    assert_focus_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        focus_pulse |=> !focus_pulse);

    assert_pulse_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(focus_pulse && jump_pulse));

    assert_mute_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !win_v |=> $stable(mute));

    assert_pending_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && two_v) |=> !pending);

    assert_bad_len_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (win_v && win_kind == WIN_BAD) |=> ($stable(track_count) && $stable(mute)
            && $stable(pending) && $stable(port_out) && !focus_pulse && !jump_pulse));
endmodule

// File: rtl/servo_cmd_rx.sv
// Module servo_cmd_rx
// Top of the serial servo command receiver: synchronises the three-wire
// link, collects strobe windows and executes the commands they carry.
// Assumes link signals are slow relative to clk (several clocks per phase).
module servo_cmd_rx
    import srx_pkg::*;
#(
    parameter int PORT_W    = 5,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_strobe,
    input  logic              cmd_clk,
    input  logic              cmd_data,
    output logic              mute,
    output logic              motor_run,
    output logic              focus_pulse,
    output logic              jump_pulse,
    output logic              jump_reverse,
    output logic              vco_x2,
    output logic [BYTE_W-1:0] track_count,
    output logic [PORT_W-1:0] port_out
);
    logic [2:0]        link_q;
    logic              win_v;
    win_kind_e         win_kind;
    logic [WORD_W-1:0] win_word;

    srx_sync #(.W(3), .STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cmd_strobe, cmd_clk, cmd_data}),
        .q     (link_q)
    );

    srx_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (link_q[2]),
        .sck      (link_q[1]),
        .sd       (link_q[0]),
        .win_v    (win_v),
        .win_kind (win_kind),
        .win_word (win_word)
    );

    srx_exec #(.PORT_W(PORT_W)) u_exec (
        .clk          (clk),
        .rst_n        (rst_n),
        .win_v        (win_v),
        .win_kind     (win_kind),
        .win_word     (win_word),
        .mute         (mute),
        .motor_run    (motor_run),
        .focus_pulse  (focus_pulse),
        .jump_pulse   (jump_pulse),
        .jump_reverse (jump_reverse),
        .vco_x2       (vco_x2),
        .track_count  (track_count),
        .port_out     (port_out)
    );
endmodule

// File: tb/servo_cmd_rx_tb.sv
module servo_cmd_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_strobe = 1'b0;
    logic       cmd_clk = 1'b0;
    logic       cmd_data = 1'b0;
    logic       mute, motor_run, focus_pulse, jump_pulse, jump_reverse, vco_x2;
    logic [7:0] track_count;
    logic [4:0] port_out;

    int n_checks = 0;
    int n_fail   = 0;
    int n_focus  = 0;
    int n_jump   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    servo_cmd_rx u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_strobe(cmd_strobe), .cmd_clk(cmd_clk),
        .cmd_data(cmd_data), .mute(mute), .motor_run(motor_run),
        .focus_pulse(focus_pulse), .jump_pulse(jump_pulse),
        .jump_reverse(jump_reverse), .vco_x2(vco_x2),
        .track_count(track_count), .port_out(port_out)
    );

    // pulse counters sampled away from the active edge
    always @(negedge clk) begin
        if (focus_pulse) n_focus++;
        if (jump_pulse)  n_jump++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w, input int n, input bit coinc);
        cmd_strobe = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            cmd_data = w[i];
            repeat (2) @(negedge clk);
            cmd_clk = 1'b1;
            if (coinc && i == 0) begin
                cmd_strobe = 1'b0;
            end else begin
                repeat (2) @(negedge clk);
                cmd_clk = 1'b0;
            end
        end
        if (!coinc) begin
            repeat (2) @(negedge clk);
            cmd_strobe = 1'b0;
        end
        repeat (8) @(negedge clk);
        cmd_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        check(mute == 0 && motor_run == 0 && vco_x2 == 0 && jump_reverse == 0, "R1 levels",
              {mute, motor_run, vco_x2, jump_reverse}, 0);
        check(track_count == 0 && port_out == 0, "R1 registers", {track_count, port_out}, 0);
        check(n_focus == 0 && n_jump == 0, "R1 pulses", n_focus + n_jump, 0);
    endtask

    task automatic t_mute;
        send(16'h30, 8, 0);
        check(mute == 1, "R4 mute on", mute, 1);
        send(16'h41, 8, 0);
        check(mute == 1, "R4 mute held", mute, 1);
        send(16'h31, 8, 0);
        check(mute == 0, "R4 mute off", mute, 0);
    endtask

    task automatic t_msb_and_idle;
        // clock edges with strobe low must be ignored
        for (int k = 0; k < 5; k++) begin
            cmd_data = 1'b1;
            repeat (2) @(negedge clk); cmd_clk = 1'b1;
            repeat (2) @(negedge clk); cmd_clk = 1'b0;
        end
        send(16'h02, 8, 0);
        check(motor_run == 0, "R2 bit order", motor_run, 0);
        send(16'h40, 8, 0);
        check(motor_run == 1, "R2 idle clocks ignored / R5 start", motor_run, 1);
    endtask

    task automatic t_motor;
        send(16'h41, 8, 0);
        check(motor_run == 0, "R5 stop", motor_run, 0);
        send(16'h40, 8, 0);
        check(motor_run == 1, "R5 start", motor_run, 1);
    endtask

    task automatic t_exec_on_fall;
        logic [7:0] w = 8'h30;
        cmd_strobe = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            cmd_data = w[i];
            repeat (2) @(negedge clk); cmd_clk = 1'b1;
            repeat (2) @(negedge clk); cmd_clk = 1'b0;
        end
        repeat (10) @(negedge clk);
        check(mute == 0, "R3 no effect before fall", mute, 0);
        cmd_strobe = 1'b0;
        repeat (8) @(negedge clk);
        check(mute == 1, "R3 effect after fall", mute, 1);
        send(16'h31, 8, 0);
    endtask

    task automatic t_focus;
        int f0 = n_focus, j0 = n_jump;
        send(16'h08, 8, 0);
        check(n_focus - f0 == 1, "R6 one focus pulse", n_focus - f0, 1);
        check(n_jump == j0, "R6 no jump pulse", n_jump - j0, 0);
    endtask

    task automatic t_jump;
        int j0 = n_jump;
        send(16'h21, 8, 0);
        check(n_jump - j0 == 1 && jump_reverse == 1, "R7 reverse jump", {n_jump - j0, jump_reverse}, 3);
        send(16'h20, 8, 0);
        check(n_jump - j0 == 2 && jump_reverse == 0, "R7 forward jump", {n_jump - j0, jump_reverse}, 4);
    endtask

    task automatic t_vco;
        send(16'hAC, 8, 0);
        check(vco_x2 == 1, "R8 vco x2", vco_x2, 1);
        send(16'hAD, 8, 0);
        check(vco_x2 == 0, "R8 vco x1", vco_x2, 0);
    endtask

    task automatic t_track;
        int f0;
        send(16'hB0, 8, 0);
        check(track_count == 0, "R9 pending no load", track_count, 0);
        f0 = n_focus;
        send(16'h08, 8, 0);
        check(track_count == 8'h08, "R9 load count", track_count, 8'h08);
        check(n_focus == f0, "R9 second byte not executed", n_focus - f0, 0);
    endtask

    task automatic t_cancel;
        int f0;
        send(16'hB0, 8, 0);
        send(16'hC003, 16, 0);
        check(port_out == 5'h03, "R10 cancelling window executed", port_out, 3);
        f0 = n_focus;
        send(16'h08, 8, 0);
        check(n_focus - f0 == 1, "R10 next byte is a command", n_focus - f0, 1);
        check(track_count == 8'h08, "R10 count unchanged", track_count, 8'h08);
    endtask

    task automatic t_port;
        send(16'hC0F6, 16, 0);
        check(port_out == 5'h16, "R11 port write", port_out, 5'h16);
    endtask

    task automatic t_bad_len;
        send(16'h30, 7, 0);
        check(mute == 0, "R12 seven bits dropped", mute, 0);
        send(16'h060, 9, 0);
        check(mute == 0, "R12 nine bits dropped", mute, 0);
        send(16'hB0, 8, 0);
        send(16'h1F, 5, 0);
        send(16'h3C, 8, 0);
        check(track_count == 8'h3C, "R12 pending survives bad window", track_count, 8'h3C);
        check(mute == 0, "R12 no mute from count byte", mute, 0);
    endtask

    task automatic t_coincident;
        send(16'h30, 8, 1);
        check(mute == 1, "R13 coincident last bit counted", mute, 1);
        send(16'h31, 8, 0);
    endtask

    task automatic t_unknown;
        int f0 = n_focus, j0 = n_jump;
        send(16'h77, 8, 0);
        send(16'h3012, 16, 0);
        check(mute == 0 && motor_run == 1 && vco_x2 == 0, "R14 levels unchanged",
              {mute, motor_run, vco_x2}, 2);
        check(port_out == 5'h16 && track_count == 8'h3C, "R14 registers unchanged",
              {track_count, port_out}, {8'h3C, 5'h16});
        check(n_focus == f0 && n_jump == j0, "R14 no pulses", n_focus + n_jump, f0 + j0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_mute;
        t_msb_and_idle;
        t_motor;
        t_exec_on_fall;
        t_focus;
        t_jump;
        t_vco;
        t_track;
        t_cancel;
        t_port;
        t_bad_len;
        t_coincident;
        t_unknown;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule